// File: doc/BRIEF.md
# Multiplexed Asynchronous Memory Write Sequencer

This block performs single write transactions to an asynchronous external memory whose address and data travel on one shared bus, as found on pseudo-static RAM and NOR flash devices. A host raises a request carrying an address, a data word, byte-lane enables and a chip-select index. While the block is not busy, the request is taken and its fields are captured. The sequencer then plays a fixed four-clock script on the memory pins, and at the end it returns a one-cycle completion pulse.

Every strobe edge falls on a system clock edge. The address is presented on the shared bus under an address-valid strobe. The bus turns to write data one clock after that strobe returns high. The write strobe sits in the middle of the chip-enable window, so that address, data and byte lanes have one clock of hold after the write strobe rises. A new request can be accepted in the same cycle that reports completion, which gives back-to-back writes with one chip-enable-high cycle between them.

Top module: `mxWriteSeq`

## Requirements
- R1: In reset and when idle, every chip enable, the address-valid strobe, the write strobe and every byte-lane line are high. The bus output enable is low, the bus output and upper address lines are zero, and busy and done are low.
- R2: A request with reqValid high is accepted at a clock edge only when busy is low. Its fields are captured at that edge. Requests and field changes while busy is high have no effect on the transfer in progress or on later outputs.
- R3: After acceptance, exactly one chip enable, the one with index reqCs (bit reqCs of memCeN), is low for exactly 4 clock periods. The other enables stay high.
- R4: The address-valid strobe is low only in the first of the 4 periods.
- R5: The write strobe is low in the second and third periods only.
- R6: The bus output enable is high for all 4 periods. The bus carries reqAddr[15:0] in periods 1 and 2 and reqData in periods 3 and 4.
- R7: For all 4 periods, memAddrHi equals reqAddr[23:16] and memBlN equals the bitwise inverse of reqBe (bit i covers data bits 8i+7..8i).
- R8: done is high for exactly the one period after the fourth, in which all chip enables are high and busy is low. busy is high for exactly the 4 active periods. A request present in the done period is accepted at its closing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Write request |
| reqAddr | input | 24 | Write address |
| reqData | input | 16 | Write data |
| reqBe | input | 2 | Byte-lane enables, active high |
| reqCs | input | 2 | Chip-select index |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle completion pulse |
| memCeN | output | 4 | Active-low chip enables |
| memAdvN | output | 1 | Active-low address-valid strobe |
| memWeN | output | 1 | Active-low write strobe |
| memBlN | output | 2 | Active-low byte-lane lines |
| memAddrHi | output | 8 | Upper address lines |
| memAdOut | output | 16 | Shared address/data bus, output value |
| memAdOe | output | 1 | Shared bus output enable |

## Verification
Completion of one write and acceptance of the next can fall in the same cycle. The bench provokes this by presenting a new request during the done period of the previous write. It then checks that done shows with all enables high, and that the new script starts on the very next period with the new chip select and address. A second overlap is a request held high during busy with changed fields. It must be ignored, and this is judged by the captured address, data and lanes staying at the first request's values for all four periods.

// File: rtl/mxw_pkg.sv
package mxw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SETUP,
    PH_DATA,
    PH_HOLD,
    PH_DONE
  } phase_t;

  typedef struct packed {
    logic accept;
    logic ceLow;
    logic advLow;
    logic weLow;
    logic busDrive;
    logic busData;
  } ctrl_t;

endpackage

// File: rtl/mxw_ctrl.sv
module mxw_ctrl
  import mxw_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  reqValid,
  output ctrl_t ctrl,
  output logic  busy,
  output logic  done
);

  phase_t phase, phaseNext;

  always_comb begin
    ctrl.accept = reqValid && !busy;
    phaseNext   = phase;
    case (phase)
      PH_IDLE:  if (ctrl.accept) phaseNext = PH_ADDR;
      PH_ADDR:  phaseNext = PH_SETUP;
      PH_SETUP: phaseNext = PH_DATA;
      PH_DATA:  phaseNext = PH_HOLD;
      PH_HOLD:  phaseNext = PH_DONE;
      PH_DONE:  phaseNext = ctrl.accept ? PH_ADDR : PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

  always_comb begin
    busy          = (phase == PH_ADDR) || (phase == PH_SETUP) ||
                    (phase == PH_DATA) || (phase == PH_HOLD);
    done          = (phase == PH_DONE);
    ctrl.ceLow    = busy;
    ctrl.advLow   = (phase == PH_ADDR);
    ctrl.weLow    = (phase == PH_SETUP) || (phase == PH_DATA);
    ctrl.busDrive = busy;
    ctrl.busData  = (phase == PH_DATA) || (phase == PH_HOLD);
  end

  // R5: write strobe low for exactly two periods
  p_we_two_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl.weLow) |=> ctrl.weLow ##1 !ctrl.weLow);

  // R8: done appears only right after the last active period
  p_done_follow_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));

  // R2: no acceptance while busy
  p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ctrl.accept);

endmodule

// File: rtl/mxw_datapath.sv
module mxw_datapath
  import mxw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int AD_W   = 16,
  parameter int NUM_CS = 4,
  localparam int BE_W  = AD_W / 8,
  localparam int HI_W  = ADDR_W - AD_W,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [AD_W-1:0]   reqData,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [CS_W-1:0]   reqCs,
  output logic [NUM_CS-1:0] memCeN,
  output logic              memAdvN,
  output logic              memWeN,
  output logic [BE_W-1:0]   memBlN,
  output logic [HI_W-1:0]   memAddrHi,
  output logic [AD_W-1:0]   memAdOut,
  output logic              memAdOe
);

  logic [ADDR_W-1:0] capAddr;
  logic [AD_W-1:0]   capData;
  logic [BE_W-1:0]   capBe;
  logic [CS_W-1:0]   capCs;

  always_ff @(posedge clk) begin
    if (rst) begin
      capAddr <= '0;
      capData <= '0;
      capBe   <= '0;
      capCs   <= '0;
    end else if (ctrl.accept) begin
      capAddr <= reqAddr;
      capData <= reqData;
      capBe   <= reqBe;
      capCs   <= reqCs;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
    assign memCeN[i] = !(ctrl.ceLow && (capCs == CS_W'(i)));
  end

  assign memAdvN   = !ctrl.advLow;
  assign memWeN    = !ctrl.weLow;
  assign memBlN    = ctrl.ceLow ? ~capBe : '1;
  assign memAddrHi = ctrl.ceLow ? capAddr[ADDR_W-1:AD_W] : '0;
  assign memAdOe   = ctrl.busDrive;
  assign memAdOut  = !ctrl.busDrive ? '0 :
                     (ctrl.busData ? capData : capAddr[AD_W-1:0]);

  // R3: never more than one chip enable low
  p_ce_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~memCeN));

  // R4: address-valid strobe low for a single period
  p_adv_single_r4: assert property (@(posedge clk) disable iff (rst)
    !memAdvN |=> memAdvN);

  // R7: upper address held while chip enable stays low
  p_hi_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (!(&memCeN) && $past(!(&memCeN))) |-> $stable(memAddrHi) && $stable(memBlN));

  // R1: bus released whenever no chip enable is low
  p_bus_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (&memCeN) |-> !memAdOe);

endmodule

// File: rtl/mxWriteSeq.sv
module mxWriteSeq
  import mxw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int AD_W   = 16,
  parameter int NUM_CS = 4,
  localparam int BE_W  = AD_W / 8,
  localparam int HI_W  = ADDR_W - AD_W,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [AD_W-1:0]   reqData,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [CS_W-1:0]   reqCs,
  output logic              busy,
  output logic              done,
  output logic [NUM_CS-1:0] memCeN,
  output logic              memAdvN,
  output logic              memWeN,
  output logic [BE_W-1:0]   memBlN,
  output logic [HI_W-1:0]   memAddrHi,
  output logic [AD_W-1:0]   memAdOut,
  output logic              memAdOe
);

  ctrl_t ctrl;

  mxw_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .ctrl     (ctrl),
    .busy     (busy),
    .done     (done)
  );

  mxw_datapath #(
    .ADDR_W (ADDR_W),
    .AD_W   (AD_W),
    .NUM_CS (NUM_CS)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .reqBe     (reqBe),
    .reqCs     (reqCs),
    .memCeN    (memCeN),
    .memAdvN   (memAdvN),
    .memWeN    (memWeN),
    .memBlN    (memBlN),
    .memAddrHi (memAddrHi),
    .memAdOut  (memAdOut),
    .memAdOe   (memAdOe)
  );

  // R6: write strobe only inside the chip-enable window
  p_we_in_ce_r6: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> !(&memCeN) && memAdOe);

endmodule

// File: tb/mxWriteSeq_tb_top.sv
module mxWriteSeq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqData = '0;
  logic [1:0]  reqBe = '0;
  logic [1:0]  reqCs = '0;
  logic        busy, done, memAdvN, memWeN, memAdOe;
  logic [3:0]  memCeN;
  logic [1:0]  memBlN;
  logic [7:0]  memAddrHi;
  logic [15:0] memAdOut;

  always #2.5 clk = ~clk;

  mxWriteSeq dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqData(reqData), .reqBe(reqBe), .reqCs(reqCs), .busy(busy),
    .done(done), .memCeN(memCeN), .memAdvN(memAdvN), .memWeN(memWeN),
    .memBlN(memBlN), .memAddrHi(memAddrHi), .memAdOut(memAdOut),
    .memAdOe(memAdOe)
  );

  typedef struct {
    logic [23:0] addr;
    logic [15:0] data;
    logic [1:0]  be;
    logic [1:0]  cs;
  } item_t;

  item_t expQ[$];
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // driver: pushes expected item once the request is taken
  task automatic issue(logic [23:0] a, logic [15:0] d, logic [1:0] b, logic [1:0] c);
    item_t it;
    do @(negedge clk); while (busy);
    reqValid = 1'b1; reqAddr = a; reqData = d; reqBe = b; reqCs = c;
    it.addr = a; it.data = d; it.be = b; it.cs = c;
    @(posedge clk);
    expQ.push_back(it);
    @(negedge clk);
    // R2: keep requesting with altered fields while busy
    reqAddr = ~a; reqData = ~d; reqBe = ~b; reqCs = c + 2'd1;
    @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: per-cycle comparison against the expected script
  int phase = 0;
  bit expDone = 0;
  item_t cur;
  always @(negedge clk) begin
    cycles++;
    if (!rst && !finished) begin
      if (phase == 0 && expQ.size() > 0) begin
        cur = expQ.pop_front();
        phase = 1;
      end else if (phase > 0 && phase < 4) begin
        phase++;
      end else if (phase == 4) begin
        phase = 0;
        expDone = 1;
        if (expQ.size() > 0) begin
          cur = expQ.pop_front();
          phase = 1;
        end
      end
      if (phase == 0 || (expDone && phase == 0)) begin
        chk("R8", {31'd0, done}, {31'd0, expDone}, "done");
        chk("R1", {28'd0, memCeN}, 32'hF, "ce idle");
        chk("R1", {29'd0, memAdvN, memWeN, memAdOe}, 32'h6, "strobes idle");
        chk("R1", {6'd0, memBlN, memAddrHi, memAdOut}, 32'h3_00_0000, "lines idle");
        chk("R8", {31'd0, busy}, 32'd0, "busy idle");
      end else begin
        chk("R8", {31'd0, done}, {31'd0, (phase == 1) && expDone}, "done active");
        chk("R8", {31'd0, busy}, 32'd1, "busy active");
        chk("R3", {28'd0, memCeN}, {28'd0, ~(4'b1 << cur.cs)}, "chip enable");
        chk("R4", {31'd0, memAdvN}, {31'd0, phase != 1}, "adv");
        chk("R5", {31'd0, memWeN}, {31'd0, !(phase == 2 || phase == 3)}, "we");
        chk("R6", {31'd0, memAdOe}, 32'd1, "oe");
        chk("R6", {16'd0, memAdOut}, {16'd0, (phase <= 2) ? cur.addr[15:0] : cur.data}, "bus");
        chk("R7", {24'd0, memAddrHi}, {24'd0, cur.addr[23:16]}, "upper addr");
        chk("R7", {30'd0, memBlN}, {30'd0, ~cur.be}, "byte lanes");
      end
      if (phase != 4 && !(phase == 1)) expDone = 0;
      if (phase == 1) expDone = 0;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset levels
    chk("R1", {28'd0, memCeN}, 32'hF, "reset ce");
    chk("R1", {27'd0, memAdvN, memWeN, memAdOe, busy, done}, 32'h18, "reset strobes");
    @(posedge clk); #1 rst = 1'b0;
    issue(24'hA5_1234, 16'hBEEF, 2'b11, 2'd0);
    repeat (3) @(negedge clk);
    issue(24'h3C_0F0F, 16'h1357, 2'b01, 2'd1);
    issue(24'hFF_FFFF, 16'h0000, 2'b10, 2'd2);   // back-to-back (R8)
    issue(24'h00_0001, 16'hFFFF, 2'b00, 2'd3);
    repeat (2) @(negedge clk);
    issue(24'h80_8000, 16'h8001, 2'b11, 2'd3);
    repeat (6) @(negedge clk);
    finished = 1;
    chk("R2", {30'd0, 2'(expQ.size())}, 32'd0, "queue drained");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule